// File: doc/BRIEF.md
# Branch and Software-Interrupt Flow Sequencer

This block steps a core through its instruction stream. It fetches one word per instruction from a synchronous-read instruction memory. The fetch address is the program counter minus four, because the counter runs four words ahead of the fetch point. The block sorts each word by its type field. It handles control flow itself: plain branches, linked branches and software interrupts. Data-processing and data-transfer words go out on a one-cycle dispatch output to the execution logic.

A linked branch keeps the previous return address when it is nonzero. It pushes that value onto an upward-growing stack through a stack write port, then overwrites the link register. A software interrupt saves the return point in the link register and jumps to its vector code plus four. An external condition-pass input decides whether a branch or interrupt takes effect. A word of all zeros stops the sequencer until the next reset. Two running totals are kept: one of executed instructions and one of cycle cost.

Top module: `flow_sequencer`

## Requirements
- R1: When reset is released, the program counter is 56, the stack pointer is 100, the link register is 0, both totals are 0, and `halted`, `disp_valid` and `stk_we` are 0.
- R2: Each fetch reads the memory word at program counter minus 4, and the program counter then increases by 1. The instruction type is bits 27:26: 00 data processing, 01 data transfer, 10 branch, 11 software interrupt.
- R3: A fetched word of zero sets `halted`. The program counter then stays fixed until reset. The zero word adds nothing to either total.
- R4: A branch takes the signed 24-bit offset in bits 23:0 (bit 23 is the sign). It moves the incremented program counter by the offset's magnitude divided by 4, truncated, in the offset's direction, and then adds 4. A branch costs 3 cycles.
- R5: A branch with bit 24 set loads the link register with the incremented program counter. If the old link value is nonzero, the old value is first written at the stack address held in the stack pointer, and the stack pointer increases by 1.
- R6: A linked branch whose old link value is zero writes nothing to the stack and leaves the stack pointer unchanged.
- R7: A software interrupt loads the link register with the incremented program counter and loads the program counter with bits 23:0 plus 4. It writes no stack entry and costs 5 cycles.
- R8: Types 00 and 01 give a one-cycle `disp_valid` pulse carrying the word. `disp_kind` is 0 for type 00 and 1 for type 01. Control flow continues in sequence. Each costs 1 cycle, whatever the value of `cond_pass`.
- R9: A branch or software interrupt seen while `cond_pass` is low changes neither the program counter, the link register nor the stack. It costs 1 cycle.
- R10: `instr_total` counts every nonzero word decoded, and `cycle_total` sums their costs.
- R11: Every instruction takes two clock cycles, a fetch and then a decode. Its results appear on the outputs after the clock edge that ends the decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | ADDR_W | Instruction memory read address (program counter minus 4) |
| imem_rdata | input | 32 | Instruction word, one cycle after the address |
| cond_pass | input | 1 | Condition result for the word under decode |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | ADDR_W | Stack write address |
| stk_wdata | output | 32 | Stack write data (old link value) |
| disp_valid | output | 1 | Dispatch pulse for data-processing or transfer words |
| disp_kind | output | 1 | 0 data processing, 1 data transfer |
| disp_word | output | 32 | Dispatched instruction word |
| pc_o | output | 32 | Program counter |
| link_o | output | 32 | Link register |
| sp_o | output | 32 | Stack pointer |
| halted | output | 1 | Set by a zero instruction word |
| cycle_total | output | CNT_W | Sum of instruction costs |
| instr_total | output | CNT_W | Number of executed instructions |

## Verification
The memory answers one cycle after an address, so the word fetched on the first edge after reset is decoded on the second edge. The dispatch pulse and all register updates for the n-th instruction are therefore visible after edge 2n. The bench counts falling edges from the release of reset and checks that dispatch pulses land on counts 2 and 4. All other checks sample on falling edges, either after `halted` rises or a fixed number of cycles later. Each expected program counter is worked out by hand from the increment at fetch, the truncated offset and the bias of four.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 24;
  localparam int LINK_BIT = 24;
  localparam int TYPE_LO  = 26;

  typedef enum logic [1:0] {
    K_DPROC = 2'b00,
    K_XFER  = 2'b01,
    K_JUMP  = 2'b10,
    K_TRAP  = 2'b11
  } fs_kind_e;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'b00,
    ST_DECODE = 2'b01,
    ST_HALT   = 2'b10
  } fs_state_e;
endpackage

// File: rtl/fs_decode.sv
module fs_decode
  import fs_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  output logic               is_zero,
  output fs_kind_e           kind,
  output logic               link,
  output logic [FIELD_W-1:0] field
);
  always_comb begin
    is_zero = (word == '0);
    kind    = fs_kind_e'(word[TYPE_LO +: 2]);
    link    = word[LINK_BIT];
    field   = word[FIELD_W-1:0];
  end
endmodule

// File: rtl/fs_target.sv
module fs_target
  import fs_pkg::*;
#(
  parameter int BIAS = 4
) (
  input  logic [WORD_W-1:0]  pc,
  input  logic [FIELD_W-1:0] field,
  output logic [WORD_W-1:0]  jump_tgt,
  output logic [WORD_W-1:0]  trap_tgt
);
  logic               neg;
  logic [FIELD_W-1:0] mag;
  logic [WORD_W-1:0]  step;

  always_comb begin
    neg  = field[FIELD_W-1];
    mag  = neg ? (~field + 1'b1) : field;
    step = WORD_W'(mag >> 2);
    jump_tgt = (neg ? (pc - step) : (pc + step)) + WORD_W'(BIAS);
    trap_tgt = WORD_W'(field) + WORD_W'(BIAS);
  end
endmodule

// File: rtl/fs_counters.sv
module fs_counters #(
  parameter int CNT_W  = 32,
  parameter int COST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic [COST_W-1:0] cost,
  output logic [CNT_W-1:0]  cycles,
  output logic [CNT_W-1:0]  instrs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cycles <= '0;
      instrs <= '0;
    end else if (step_en) begin
      cycles <= cycles + CNT_W'(cost);
      instrs <= instrs + 1'b1;
    end
  end

  AST_INSTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (instrs != $past(instrs)) |-> (instrs == $past(instrs) + 1'b1)); // R10
endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import fs_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int CNT_W     = 32,
  parameter int RESET_PC  = 56,
  parameter int RESET_SP  = 100,
  parameter int PIPE_BIAS = 4,
  parameter int JUMP_COST = 3,
  parameter int TRAP_COST = 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [31:0]       imem_rdata,
  input  logic              cond_pass,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [31:0]       stk_wdata,
  output logic              disp_valid,
  output logic              disp_kind,
  output logic [31:0]       disp_word,
  output logic [31:0]       pc_o,
  output logic [31:0]       link_o,
  output logic [31:0]       sp_o,
  output logic              halted,
  output logic [CNT_W-1:0]  cycle_total,
  output logic [CNT_W-1:0]  instr_total
);
  localparam int COST_W = 8;

  fs_state_e          state_q;
  logic [WORD_W-1:0]  pc_q, lr_q, sp_q;
  logic               d_zero, d_link;
  fs_kind_e           d_kind;
  logic [FIELD_W-1:0] d_field;
  logic [WORD_W-1:0]  jump_tgt, trap_tgt;
  logic               in_decode, take_flow;
  logic [COST_W-1:0]  cost;

  fs_decode u_dec (
    .word(imem_rdata), .is_zero(d_zero), .kind(d_kind),
    .link(d_link), .field(d_field)
  );

  fs_target #(.BIAS(PIPE_BIAS)) u_tgt (
    .pc(pc_q), .field(d_field), .jump_tgt(jump_tgt), .trap_tgt(trap_tgt)
  );

  always_comb begin
    in_decode = (state_q == ST_DECODE) && !d_zero;
    take_flow = cond_pass && (d_kind == K_JUMP || d_kind == K_TRAP);
    if (take_flow && d_kind == K_JUMP)      cost = COST_W'(JUMP_COST);
    else if (take_flow && d_kind == K_TRAP) cost = COST_W'(TRAP_COST);
    else                                    cost = COST_W'(1);
  end

  fs_counters #(.CNT_W(CNT_W), .COST_W(COST_W)) u_cnt (
    .clk(clk), .rst(rst), .step_en(in_decode), .cost(cost),
    .cycles(cycle_total), .instrs(instr_total)
  );

  assign imem_addr = ADDR_W'(pc_q - WORD_W'(PIPE_BIAS));
  assign pc_o   = pc_q;
  assign link_o = lr_q;
  assign sp_o   = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_FETCH;
      pc_q       <= WORD_W'(RESET_PC);
      lr_q       <= '0;
      sp_q       <= WORD_W'(RESET_SP);
      halted     <= 1'b0;
      stk_we     <= 1'b0;
      stk_addr   <= '0;
      stk_wdata  <= '0;
      disp_valid <= 1'b0;
      disp_kind  <= 1'b0;
      disp_word  <= '0;
    end else begin
      stk_we     <= 1'b0;
      disp_valid <= 1'b0;
      case (state_q)
        ST_FETCH: begin
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (d_zero) begin
            halted  <= 1'b1;
            state_q <= ST_HALT;
          end else begin
            state_q <= ST_FETCH;
            case (d_kind)
              K_DPROC, K_XFER: begin
                disp_valid <= 1'b1;
                disp_kind  <= (d_kind == K_XFER);
                disp_word  <= imem_rdata;
              end
              K_JUMP: if (cond_pass) begin
                if (d_link) begin
                  if (lr_q != '0) begin
                    stk_we    <= 1'b1;
                    stk_addr  <= ADDR_W'(sp_q);
                    stk_wdata <= lr_q;
                    sp_q      <= sp_q + 1'b1;
                  end
                  lr_q <= pc_q;
                end
                pc_q <= jump_tgt;
              end
              default: if (cond_pass) begin
                lr_q <= pc_q;
                pc_q <= trap_tgt;
              end
            endcase
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    (sp_q != $past(sp_q)) |-> (sp_q == $past(sp_q) + 1'b1)); // R5
  AST_PUSH_NONZERO: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> (stk_wdata != '0)); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc_q))); // R3
  AST_DISP_SPACING: assert property (@(posedge clk) disable iff (rst)
    disp_valid |=> !disp_valid); // R11
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({disp_valid, stk_we})); // R8
endmodule

// File: tb/flow_sequencer_tb_top.sv
module flow_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cond_pass = 1'b1;
  logic [9:0]  imem_addr, stk_addr;
  logic [31:0] imem_rdata, stk_wdata, disp_word, pc_o, link_o, sp_o;
  logic        stk_we, disp_valid, disp_kind, halted;
  logic [31:0] cycle_total, instr_total;

  logic [31:0] mem [0:1023];
  int tests = 0, fails = 0;
  int cyc, npush, ndisp;
  logic [31:0] push_addr, push_data;
  int          dcyc [0:3];
  logic [31:0] dword [0:3];
  logic        dkind [0:3];

  always #4 clk = ~clk;

  flow_sequencer dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .cond_pass(cond_pass), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .disp_valid(disp_valid), .disp_kind(disp_kind),
    .disp_word(disp_word), .pc_o(pc_o), .link_o(link_o), .sp_o(sp_o),
    .halted(halted), .cycle_total(cycle_total), .instr_total(instr_total)
  );

  always @(posedge clk) imem_rdata <= mem[imem_addr];

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; npush = 0; ndisp = 0;
    end else begin
      cyc++;
      if (stk_we) begin
        npush++; push_addr = 32'(stk_addr); push_data = stk_wdata;
      end
      if (disp_valid && ndisp < 4) begin
        dcyc[ndisp] = cyc; dword[ndisp] = disp_word; dkind[ndisp] = disp_kind;
        ndisp++;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic start(input logic cp);
    rst = 1'b1;
    cond_pass = cp;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic release_rst();
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic run_to_halt(input string req);
    int n = 0;
    while (!halted && n < 300) begin
      @(negedge clk); #1; n++;
    end
    chk(req, "halt reached", 32'(halted), 32'd1);
  endtask

  task automatic t_reset();
    start(1'b1);
    mem[52] = 32'hE3A00001;
    release_rst();
    chk("R1", "pc", pc_o, 32'd56);
    chk("R1", "sp", sp_o, 32'd100);
    chk("R1", "link", link_o, 32'd0);
    chk("R1", "cycles", cycle_total, 32'd0);
    chk("R1", "instrs", instr_total, 32'd0);
    chk("R1", "flags", {29'd0, halted, disp_valid, stk_we}, 32'd0);
    chk("R2", "fetch addr", 32'(imem_addr), 32'd52);
  endtask

  task automatic t_halt();
    start(1'b1);
    release_rst();
    run_to_halt("R3");
    repeat (5) @(negedge clk);
    #1;
    chk("R3", "pc frozen", pc_o, 32'd57);
    chk("R3", "instrs", instr_total, 32'd0);
    chk("R3", "cycles", cycle_total, 32'd0);
  endtask

  task automatic t_jump_fwd();
    start(1'b1);
    mem[52] = 32'hEA000010;
    release_rst();
    run_to_halt("R4");
    chk("R4", "pc after +16", pc_o, 32'd66);
    chk("R4", "cycles", cycle_total, 32'd3);
    chk("R4", "link untouched", link_o, 32'd0);
  endtask

  task automatic t_jump_back();
    start(1'b1);
    mem[52] = 32'hEAFFFFE0;
    release_rst();
    run_to_halt("R4");
    chk("R4", "pc after -32", pc_o, 32'd54);
    start(1'b1);
    mem[52] = 32'hEAFFFFFA;
    release_rst();
    run_to_halt("R4");
    chk("R4", "pc after -6 truncated", pc_o, 32'd61);
    start(1'b1);
    mem[52] = 32'hEA000006;
    release_rst();
    run_to_halt("R4");
    chk("R4", "pc after +6 truncated", pc_o, 32'd63);
  endtask

  task automatic t_link();
    start(1'b1);
    mem[52] = 32'hEB000000;
    mem[57] = 32'hEB000000;
    release_rst();
    run_to_halt("R5");
    chk("R6", "first call no push, one push total", 32'(npush), 32'd1);
    chk("R5", "pushed addr", push_addr, 32'd100);
    chk("R5", "pushed old link", push_data, 32'd57);
    chk("R5", "sp", sp_o, 32'd101);
    chk("R5", "link", link_o, 32'd62);
    chk("R5", "pc", pc_o, 32'd67);
    chk("R10", "instrs", instr_total, 32'd2);
    chk("R10", "cycles", cycle_total, 32'd6);
  endtask

  task automatic t_trap();
    start(1'b1);
    mem[52] = 32'hEF000010;
    release_rst();
    run_to_halt("R7");
    chk("R7", "link", link_o, 32'd57);
    chk("R7", "pc", pc_o, 32'd21);
    chk("R7", "cycles", cycle_total, 32'd5);
    chk("R7", "no push", 32'(npush), 32'd0);
    chk("R7", "sp", sp_o, 32'd100);
  endtask

  task automatic t_dispatch();
    start(1'b0);
    mem[52] = 32'hE3A04064;
    mem[53] = 32'hE6E34001;
    release_rst();
    run_to_halt("R8");
    chk("R8", "pulses", 32'(ndisp), 32'd2);
    chk("R8", "word0", dword[0], 32'hE3A04064);
    chk("R8", "kind0", 32'(dkind[0]), 32'd0);
    chk("R8", "word1", dword[1], 32'hE6E34001);
    chk("R8", "kind1", 32'(dkind[1]), 32'd1);
    chk("R11", "pulse0 cycle", 32'(dcyc[0]), 32'd2);
    chk("R11", "pulse1 cycle", 32'(dcyc[1]), 32'd4);
    chk("R8", "pc", pc_o, 32'd59);
    chk("R10", "cycles", cycle_total, 32'd2);
  endtask

  task automatic t_cond_fail();
    start(1'b0);
    mem[52] = 32'hEB000010;
    mem[53] = 32'hEF000010;
    release_rst();
    run_to_halt("R9");
    chk("R9", "pc sequential", pc_o, 32'd59);
    chk("R9", "link", link_o, 32'd0);
    chk("R9", "no push", 32'(npush), 32'd0);
    chk("R9", "cycles", cycle_total, 32'd2);
    chk("R10", "instrs", instr_total, 32'd2);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_halt();
    t_jump_fwd();
    t_jump_back();
    t_link();
    t_trap();
    t_dispatch();
    t_cond_fail();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule